// File: doc/BRIEF.md
# Embedded-Clock Serial Framer

This block is the transmit half of a 10-bit serial link that carries its own clock inside the bit stream. Each word period it takes one parallel data word and sends it out as a 12-slot frame, one slot per bit-clock enable. The frame opens with a forced high slot and closes with a forced low slot. The low-to-high step from the closing slot of one frame into the opening slot of the next gives a receiver a rising edge it can always recover the frame clock from.

Two synchronization request inputs replace the data frame with a fixed sync frame. A sync frame is the first half of its slots high and the second half low, so its only rising edge lies on the frame boundary, and a receiver can find frame alignment without ambiguity. The bit clock is an enable pulse of one cycle at twelve times the word rate. Data, valid and sync requests are sampled only at frame boundaries.

Top module: `serial_framer`

## Requirements
- R1: While reset is held, and afterwards until the first cycle with `bit_en` high, `ser_out` is 1 and `frame_start` is 0.
- R2: The first `bit_en` after reset begins a frame. Its opening slot appears on `ser_out` and `frame_start` is 1 for that slot.
- R3: Every frame is exactly 12 bit-enable slots long. `frame_start` is 1 during slot 0 of each frame and 0 during slots 1 to 11.
- R4: Slot 0 of every frame is 1 and slot 11 is 0.
- R5: In a data frame, slots 1 to 10 carry `word_data` bits 0 to 9 in that order, least significant bit first.
- R6: If `word_valid` is 0 at the frame boundary, slots 1 to 10 are all 0.
- R7: If `sync_req_a` or `sync_req_b` is 1 at the frame boundary, the frame is slots 0 to 5 high and slots 6 to 11 low, whatever the data.
- R8: A sync frame that follows any complete frame contains exactly one 0-to-1 transition, which falls on its slot 0.
- R9: Data, valid and sync requests are sampled only on the bit enable that starts a frame. Changes during slots 1 to 11 have no effect on the frame in progress.
- R10: `ser_out` and `frame_start` change only on clock edges where `bit_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Single-cycle bit-clock enable, one per serial slot |
| word_data | input | 10 | Parallel word to send |
| word_valid | input | 1 | Word present; if low, a zero payload is framed |
| sync_req_a | input | 1 | Sync frame request, first source |
| sync_req_b | input | 1 | Sync frame request, second source |
| ser_out | output | 1 | Serial bit stream |
| frame_start | output | 1 | High while the opening slot of a frame is on `ser_out` |

## Verification
The main check sweeps all 1024 data words through back-to-back frames. This separates bit-order faults and stuck payload bits from faults in the framing slots. Frames with `word_valid` low, and with each sync request alone and both together, show whether zero filling and sync selection follow the inputs sampled at the boundary. After the first slot of every frame, the bench inverts all inputs, so any sampling outside the boundary shows up as a corrupted frame. Runs with idle cycles between bit enables show whether the outputs move without an enable or whether the framer counts clocks instead of enables.

// File: rtl/serial_framer.sv
module serial_framer #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] word_data,
  input  logic              word_valid,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  output logic              ser_out,
  output logic              frame_start
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int ONES    = FRAME_W / 2;

  logic [FRAME_W-1:0] data_frame, sync_frame, next_frame, shreg;
  logic [CNT_W-1:0]   left;
  logic               boundary;

  assign data_frame = {1'b0, (word_valid ? word_data : {DATA_W{1'b0}}), 1'b1};
  assign sync_frame = {{(FRAME_W-ONES){1'b0}}, {ONES{1'b1}}};
  assign next_frame = (sync_req_a | sync_req_b) ? sync_frame : data_frame;
  assign boundary   = (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg       <= '0;
      left        <= '0;
      ser_out     <= 1'b1;
      frame_start <= 1'b0;
    end else if (bit_en) begin
      if (boundary) begin
        ser_out     <= next_frame[0];
        shreg       <= next_frame >> 1;
        left        <= CNT_W'(FRAME_W - 1);
        frame_start <= 1'b1;
      end else begin
        ser_out     <= shreg[0];
        shreg       <= shreg >> 1;
        left        <= left - 1'b1;
        frame_start <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_framer_chk.sv
module serial_framer_chk #(
  parameter int FRAME_W = 12
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic ser_out,
  input logic frame_start
);
  logic       seen;
  logic [7:0] en_cnt;
  logic       fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      en_cnt <= '0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= frame_start;
      seen <= seen | frame_start;
      if (frame_start && !fs_q) en_cnt <= bit_en ? 8'd2 : 8'd1;
      else if (bit_en)          en_cnt <= en_cnt + 8'd1;
    end
  end

  AST_START_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ser_out); // R4
  AST_END_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fs_q && seen) |-> !$past(ser_out)); // R4
  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(ser_out) && $stable(frame_start))); // R10
  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fs_q && seen) |-> (en_cnt == 8'(FRAME_W + 1))); // R3
endmodule

bind serial_framer serial_framer_chk #(.FRAME_W(DATA_W + 2)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
  .ser_out(ser_out), .frame_start(frame_start)
);

// File: tb/serial_framer_tb.sv
module serial_framer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic [9:0] word_data = '0;
  logic word_valid = 1'b0;
  logic sync_req_a = 1'b0;
  logic sync_req_b = 1'b0;
  logic ser_out, frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic last_bit = 1'b1;

  always #5 clk = ~clk;

  serial_framer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_data(word_data),
    .word_valid(word_valid), .sync_req_a(sync_req_a), .sync_req_b(sync_req_b),
    .ser_out(ser_out), .frame_start(frame_start)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [9:0] d, input logic v, input logic sa,
                           input logic sb, input int gap);
    int rises = 0;
    logic sy = sa | sb;
    word_data = d; word_valid = v; sync_req_a = sa; sync_req_b = sb;
    for (int i = 0; i < 12; i++) begin
      int exp;
      @(negedge clk) bit_en = 1'b1;
      @(negedge clk) bit_en = 1'b0;
      if (sy)           exp = (i < 6) ? 1 : 0;
      else if (i == 0)  exp = 1;
      else if (i == 11) exp = 0;
      else              exp = v ? int'(d[i-1]) : 0;
      if (sy)                     chk(ser_out, exp, "R7 R9");
      else if (i == 0 || i == 11) chk(ser_out, exp, "R4");
      else if (v)                 chk(ser_out, exp, "R5 R9");
      else                        chk(ser_out, exp, "R6 R9");
      chk(frame_start, (i == 0) ? 1 : 0, "R3");
      if (!last_bit && ser_out) rises++;
      last_bit = ser_out;
      if (i == 0) begin
        word_data = ~d; word_valid = ~v; sync_req_a = ~sa; sync_req_b = ~sb;
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(ser_out, exp, "R10");
        chk(frame_start, (i == 0) ? 1 : 0, "R10");
      end
    end
    if (sy) chk(rises, 1, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_out, 1, "R1");
    chk(frame_start, 0, "R1");
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(ser_out, 1, "R1");
      chk(frame_start, 0, "R1");
    end
    @(negedge clk) bit_en = 1'b1; word_data = 10'h2A5; word_valid = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    chk(frame_start, 1, "R2");
    chk(ser_out, 1, "R2");
    for (int i = 1; i < 12; i++) begin
      @(negedge clk) bit_en = 1'b1;
      @(negedge clk) bit_en = 1'b0;
      chk(ser_out, (i == 11) ? 0 : int'(10'h2A5 >> (i-1)) & 1, "R2 R5");
      chk(frame_start, 0, "R3");
    end
    last_bit = 1'b0;
    for (int d = 0; d < 1024; d++) run_frame(10'(d), 1'b1, 1'b0, 1'b0, 0);
    run_frame(10'h3FF, 1'b0, 1'b0, 1'b0, 0);
    run_frame(10'h155, 1'b0, 1'b0, 1'b0, 1);
    run_frame(10'h3FF, 1'b1, 1'b1, 1'b0, 0);
    run_frame(10'h3FF, 1'b1, 1'b0, 1'b1, 0);
    run_frame(10'h000, 1'b1, 1'b1, 1'b1, 2);
    run_frame(10'h2AA, 1'b1, 1'b1, 1'b0, 0);
    run_frame(10'h1C3, 1'b1, 1'b0, 1'b0, 3);
    run_frame(10'h3FF, 1'b1, 1'b0, 1'b0, 2);
    run_frame(10'h0F0, 1'b0, 1'b0, 1'b1, 1);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule